// File: doc/BRIEF.md
# Dual Wiper Position Register Command Unit

This block keeps the position registers of two independent resistor-divider wipers and applies position-changing commands to them. A command arrives already decoded from the serial front end as a one-cycle strobe with a 4-bit opcode, a channel address bit and a data byte. Depending on the opcode the unit loads the byte, moves a wiper by one step, or moves it by a 6 dB step (halving or doubling). The command goes to the addressed channel or to both channels together. Every step and shift saturates at the ends of the code range.

A reload path from the nonvolatile store controller overwrites both wipers at once. It takes priority over any command in the same cycle. A write-protect level blocks every command that would change a wiper. A read command copies the addressed wiper into a read-back byte, which the serial front end shifts out.

Top module: `wiper_cmd_unit`

## Requirements
- R1: After reset both wipers hold midscale 0x80 and the read-back byte is 0x00.
- R2: Opcode 11 loads the data byte into the wiper selected by the address bit (0 selects wiper 0, 1 selects wiper 1). The new value is visible on the next clock. The other wiper keeps its value.
- R3: Opcodes 14 (addressed) and 15 (both) add one to a wiper and stop at 0xFF.
- R4: Opcodes 6 (addressed) and 7 (both) subtract one from a wiper and stop at 0x00.
- R5: Opcodes 4 (addressed) and 5 (both) shift a wiper right by one bit as a logical shift, so 0x00 stays 0x00.
- R6: Opcodes 12 (addressed) and 13 (both) double a wiper. 0x00 becomes 0x01, and any value of 0x80 or more becomes 0xFF.
- R7: Opcodes 5, 7, 13 and 15 update both wipers in the same clock cycle, whatever the address bit.
- R8: The step and shift opcodes (4, 5, 6, 7, 12, 13, 14, 15) ignore the data byte.
- R9: While wr_protect_i is high, no command changes either wiper. Reads still work.
- R10: Opcode 10 copies the addressed wiper into rdback_o on the next clock. rdback_o keeps its value until the next read.
- R11: A reload strobe writes both reload values into the wipers on the next clock. It overrides a command in the same cycle and is not blocked by write protect.
- R12: Opcodes not listed above (0, 1, 2, 3, 8, 9) and cycles with no strobe leave both wipers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 4 | Command opcode |
| cmd_addr_i | input | 1 | Channel select: 0 selects wiper 0, 1 selects wiper 1 |
| cmd_data_i | input | 8 | Data byte used by the load command |
| wr_protect_i | input | 1 | High blocks wiper changes by commands |
| reload_i | input | 1 | Reload strobe from the store controller |
| reload_wiper0_i | input | 8 | Reload value for wiper 0 |
| reload_wiper1_i | input | 8 | Reload value for wiper 1 |
| wiper0_o | output | 8 | Wiper 0 position |
| wiper1_o | output | 8 | Wiper 1 position |
| rdback_o | output | 8 | Last wiper value read |

## Verification
The assertions assume that cmd_valid_i and reload_i are single-cycle strobes sampled on the rising edge. They also assume that the opcode, address and data are stable while the strobe is high. The bench drives every input on the falling edge and drops the strobe after one cycle, so those conditions always hold. The bench never holds reset active in the middle of a command. It exercises reload together with a command only in a deliberate collision test, because that case is where the priority rule applies.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_LOAD,
    K_UP,
    K_DOWN,
    K_DBL,
    K_HALF
  } op_kind_e;

  localparam logic [3:0] OP_HALF_ONE = 4'd4;
  localparam logic [3:0] OP_HALF_ALL = 4'd5;
  localparam logic [3:0] OP_DOWN_ONE = 4'd6;
  localparam logic [3:0] OP_DOWN_ALL = 4'd7;
  localparam logic [3:0] OP_READ     = 4'd10;
  localparam logic [3:0] OP_LOAD     = 4'd11;
  localparam logic [3:0] OP_DBL_ONE  = 4'd12;
  localparam logic [3:0] OP_DBL_ALL  = 4'd13;
  localparam logic [3:0] OP_UP_ONE   = 4'd14;
  localparam logic [3:0] OP_UP_ALL   = 4'd15;
endpackage

// File: rtl/wiper_decode.sv
module wiper_decode
  import wiper_pkg::*;
(
  input  logic [3:0] op_i,
  output op_kind_e   kind_o,
  output logic       group_o,
  output logic       read_o
);
  always_comb begin
    kind_o  = K_NONE;
    group_o = 1'b0;
    read_o  = 1'b0;
    case (op_i)
      OP_HALF_ONE: kind_o = K_HALF;
      OP_HALF_ALL: begin kind_o = K_HALF; group_o = 1'b1; end
      OP_DOWN_ONE: kind_o = K_DOWN;
      OP_DOWN_ALL: begin kind_o = K_DOWN; group_o = 1'b1; end
      OP_READ:     read_o = 1'b1;
      OP_LOAD:     kind_o = K_LOAD;
      OP_DBL_ONE:  kind_o = K_DBL;
      OP_DBL_ALL:  begin kind_o = K_DBL; group_o = 1'b1; end
      OP_UP_ONE:   kind_o = K_UP;
      OP_UP_ALL:   begin kind_o = K_UP; group_o = 1'b1; end
      default:     kind_o = K_NONE;
    endcase
  end
endmodule

// File: rtl/wiper_next.sv
module wiper_next
  import wiper_pkg::*;
#(
  parameter int W = 8
) (
  input  op_kind_e       kind_i,
  input  logic [W-1:0]   cur_i,
  input  logic [W-1:0]   data_i,
  output logic [W-1:0]   nxt_o
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};
  localparam logic [W-1:0] ONE_V = W'(1);

  always_comb begin
    nxt_o = cur_i;
    case (kind_i)
      K_LOAD: nxt_o = data_i;
      K_UP:   nxt_o = (cur_i == MAX_V) ? MAX_V : cur_i + ONE_V;
      K_DOWN: nxt_o = (cur_i == '0) ? '0 : cur_i - ONE_V;
      K_HALF: nxt_o = cur_i >> 1;
      // doubling: zero seeds to one, top half pins to full scale
      K_DBL: begin
        if (cur_i == '0)          nxt_o = ONE_V;
        else if (cur_i[W-1])      nxt_o = MAX_V;
        else                      nxt_o = cur_i << 1;
      end
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/wiper_slice.sv
module wiper_slice
  import wiper_pkg::*;
#(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = W'(1) << (W-1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  op_kind_e     kind_i,
  input  logic [W-1:0] data_i,
  input  logic         reload_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] wiper_o
);
  logic [W-1:0] nxt;

  wiper_next #(.W(W)) u_next (
    .kind_i (kind_i),
    .cur_i  (wiper_o),
    .data_i (data_i),
    .nxt_o  (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wiper_o <= RST_VAL;
    else if (reload_i) wiper_o <= reload_val_i;
    else if (en_i)     wiper_o <= nxt;
  end

  p_reload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> wiper_o == $past(reload_val_i));

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reload_i) |=> $stable(wiper_o));

  p_up_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && kind_i == K_UP && wiper_o == {W{1'b1}}) |=> wiper_o == {W{1'b1}});

  p_down_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && kind_i == K_DOWN && wiper_o == '0) |=> wiper_o == '0);

  p_dbl_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && kind_i == K_DBL && wiper_o[W-1]) |=> wiper_o == {W{1'b1}});

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && kind_i == K_LOAD) |=> wiper_o == $past(data_i));
endmodule

// File: rtl/wiper_cmd_unit.sv
module wiper_cmd_unit
  import wiper_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic [3:0]   cmd_op_i,
  input  logic         cmd_addr_i,
  input  logic [W-1:0] cmd_data_i,
  input  logic         wr_protect_i,
  input  logic         reload_i,
  input  logic [W-1:0] reload_wiper0_i,
  input  logic [W-1:0] reload_wiper1_i,
  output logic [W-1:0] wiper0_o,
  output logic [W-1:0] wiper1_o,
  output logic [W-1:0] rdback_o
);
  localparam int NCH = 2;

  op_kind_e     kind;
  logic         group;
  logic         is_read;
  logic [W-1:0] reload_arr [NCH];
  logic [W-1:0] wiper_arr  [NCH];

  assign reload_arr[0] = reload_wiper0_i;
  assign reload_arr[1] = reload_wiper1_i;

  wiper_decode u_dec (
    .op_i    (cmd_op_i),
    .kind_o  (kind),
    .group_o (group),
    .read_o  (is_read)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = cmd_valid_i && !wr_protect_i && (kind != K_NONE)
                 && (group || (cmd_addr_i == 1'(ch)));

    wiper_slice #(.W(W)) u_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (hit),
      .kind_i       (kind),
      .data_i       (cmd_data_i),
      .reload_i     (reload_i),
      .reload_val_i (reload_arr[ch]),
      .wiper_o      (wiper_arr[ch])
    );
  end

  assign wiper0_o = wiper_arr[0];
  assign wiper1_o = wiper_arr[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rdback_o <= '0;
    else if (cmd_valid_i && is_read) rdback_o <= cmd_addr_i ? wiper1_o : wiper0_o;
  end

  p_wp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && wr_protect_i && !reload_i) |=> ($stable(wiper0_o) && $stable(wiper1_o)));

  p_group_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !wr_protect_i && !reload_i && cmd_op_i == OP_UP_ALL
     && wiper0_o != {W{1'b1}} && wiper1_o != {W{1'b1}})
    |=> (wiper0_o == $past(wiper0_o) + W'(1)) && (wiper1_o == $past(wiper1_o) + W'(1)));

  p_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_READ)
    |=> rdback_o == ($past(cmd_addr_i) ? $past(wiper1_o) : $past(wiper0_o)));

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_op_i == OP_READ) |=> $stable(rdback_o));
endmodule

// File: tb/tb_wiper_cmd_unit.sv
`timescale 1ns/1ps
module tb_wiper_cmd_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [3:0] cmd_op_i = '0;
  logic       cmd_addr_i = 1'b0;
  logic [7:0] cmd_data_i = '0;
  logic       wr_protect_i = 1'b0;
  logic       reload_i = 1'b0;
  logic [7:0] reload_wiper0_i = '0;
  logic [7:0] reload_wiper1_i = '0;
  logic [7:0] wiper0_o, wiper1_o, rdback_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wiper_cmd_unit dut (.*);

  // {req, op, addr, data, wp, exp0, exp1}
  localparam int NV = 26;
  localparam logic [33:0] VEC [NV] = '{
    {4'd2,  4'd11, 1'b0, 8'h40, 1'b0, 8'h40, 8'h80},
    {4'd2,  4'd11, 1'b1, 8'hFE, 1'b0, 8'h40, 8'hFE},
    {4'd3,  4'd14, 1'b1, 8'h00, 1'b0, 8'h40, 8'hFF},
    {4'd3,  4'd14, 1'b1, 8'h00, 1'b0, 8'h40, 8'hFF},  // R3 saturation
    {4'd7,  4'd15, 1'b0, 8'h33, 1'b0, 8'h41, 8'hFF},  // R7 R8
    {4'd4,  4'd6,  1'b0, 8'h00, 1'b0, 8'h40, 8'hFF},
    {4'd7,  4'd7,  1'b0, 8'h00, 1'b0, 8'h3F, 8'hFE},
    {4'd2,  4'd11, 1'b0, 8'h00, 1'b0, 8'h00, 8'hFE},
    {4'd4,  4'd6,  1'b0, 8'h00, 1'b0, 8'h00, 8'hFE},  // R4 saturation
    {4'd6,  4'd12, 1'b0, 8'h00, 1'b0, 8'h01, 8'hFE},  // R6 zero to one
    {4'd6,  4'd12, 1'b0, 8'h00, 1'b0, 8'h02, 8'hFE},
    {4'd6,  4'd12, 1'b1, 8'h00, 1'b0, 8'h02, 8'hFF},  // R6 top half
    {4'd5,  4'd4,  1'b1, 8'h00, 1'b0, 8'h02, 8'h7F},
    {4'd7,  4'd13, 1'b0, 8'h00, 1'b0, 8'h04, 8'hFE},
    {4'd8,  4'd5,  1'b1, 8'hAA, 1'b0, 8'h02, 8'h7F},  // R8 R5
    {4'd2,  4'd11, 1'b0, 8'h80, 1'b0, 8'h80, 8'h7F},
    {4'd6,  4'd12, 1'b0, 8'h00, 1'b0, 8'hFF, 8'h7F},  // R6 exactly midscale
    {4'd5,  4'd4,  1'b0, 8'h00, 1'b0, 8'h7F, 8'h7F},
    {4'd9,  4'd11, 1'b1, 8'h01, 1'b1, 8'h7F, 8'h7F},  // R9
    {4'd9,  4'd15, 1'b0, 8'h00, 1'b1, 8'h7F, 8'h7F},  // R9
    {4'd12, 4'd0,  1'b0, 8'h55, 1'b0, 8'h7F, 8'h7F},  // R12
    {4'd12, 4'd3,  1'b0, 8'h55, 1'b0, 8'h7F, 8'h7F},  // R12
    {4'd2,  4'd11, 1'b1, 8'h01, 1'b0, 8'h7F, 8'h01},
    {4'd5,  4'd4,  1'b1, 8'h00, 1'b0, 8'h7F, 8'h00},
    {4'd5,  4'd5,  1'b0, 8'h00, 1'b0, 8'h3F, 8'h00},  // R5 zero stays
    {4'd7,  4'd7,  1'b0, 8'h00, 1'b0, 8'h3E, 8'h00}   // R7 R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // drive at falling edge, one rising edge, sample at next falling edge
  task automatic issue(input logic [3:0] op, input logic a, input logic [7:0] d, input logic wp);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d; wr_protect_i = wp;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; wr_protect_i = 1'b0;
  endtask

  initial begin
    #(200000.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 wiper0", wiper0_o, 8'h80);
    check("R1 wiper1", wiper1_o, 8'h80);
    check("R1 rdback", rdback_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string tag;
      v = VEC[i];
      issue(v[29:26], v[25], v[24:17], v[16]);
      tag = $sformatf("R%0d vec%0d", v[33:30], i);
      check({tag, " w0"}, wiper0_o, v[15:8]);
      check({tag, " w1"}, wiper1_o, v[7:0]);
    end

    // R10 reads, including under write protect
    issue(4'd10, 1'b0, 8'h00, 1'b0);
    check("R10 read w0", rdback_o, 8'h3E);
    issue(4'd10, 1'b1, 8'h00, 1'b1);
    check("R10 R9 read w1 under protect", rdback_o, 8'h00);
    issue(4'd11, 1'b0, 8'h9C, 1'b0);
    check("R10 hold", rdback_o, 8'h00);
    check("R2 load after read", wiper0_o, 8'h9C);

    // R11 reload beats same-cycle command and ignores protect
    reload_i = 1'b1; reload_wiper0_i = 8'h11; reload_wiper1_i = 8'h22;
    issue(4'd11, 1'b0, 8'h99, 1'b1);
    reload_i = 1'b0;
    check("R11 w0", wiper0_o, 8'h11);
    check("R11 w1", wiper1_o, 8'h22);
    reload_i = 1'b1; reload_wiper0_i = 8'hA5; reload_wiper1_i = 8'h5A;
    issue(4'd15, 1'b0, 8'h00, 1'b0);
    reload_i = 1'b0;
    check("R11 group collision w0", wiper0_o, 8'hA5);
    check("R11 group collision w1", wiper1_o, 8'h5A);

    // R1 reset again mid-run
    issue(4'd10, 1'b1, 8'h00, 1'b0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 re-reset w0", wiper0_o, 8'h80);
    check("R1 re-reset w1", wiper1_o, 8'h80);
    check("R1 re-reset rdback", rdback_o, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule